// File: doc/BRIEF.md
# Packet Buffer Memory Arbiter

This block lets four fixed-role streams share one single-ported external SRAM that holds packet data. Two streams write into memory: the receiver storing incoming frames and the host loading frames to send. Two read from it: the host fetching received frames and the transmitter pulling frames onto the wire. Each stream has its own small FIFO. An arbiter picks at most one of them per clock and drives the SRAM strobes for it. All four streams can therefore run at the same time, and each one sees what behaves like its own memory.

The write ports accept data whenever their FIFO has room. The read ports prefetch from memory whenever their FIFO has room for the returned word. Addresses come from four pointer inputs kept outside the block. `slot_grant` tells the pointer owner which pointer to advance at the end of the current cycle. The host uses one data port in each direction. That port is the programmed-I/O register and also the DMA target, and `host_mode` selects the DMA request style. The block alone generates every chip-enable and write-enable to the SRAM, one cycle after the grant.

All four streams use valid/ready. A transfer happens on a rising edge where both valid and ready are high. A producer keeps valid and data steady until ready is high, and valid never waits for ready. The SRAM is expected to return read data combinationally, in the same cycle that `mem_ce` is high.

Top module: `pkt_buf_arbiter`

## Requirements
- R1: `rxw_ready` and `hwr_ready` are high exactly when their FIFO holds fewer than DEPTH words. An accepted word is stored at the tail of that FIFO.
- R2: `hrd_valid` and `txr_valid` are high exactly when their FIFO is non-empty. Words come out in the order their memory reads were granted, and each word is the memory content at that read's address.
- R3: At most one bit of `slot_grant` is high in any cycle. A grant in cycle t makes `mem_ce` high in cycle t+1, with `mem_we` high for write ports and low for read ports. A cycle with no grant leaves `mem_ce` low in the next cycle. For a write, `mem_wdata` carries the head word of the granted FIFO.
- R4: The grant bit positions are: bit 0 receiver write, bit 1 host read, bit 2 host write, bit 3 transmitter read. An eligible receiver write always wins. Otherwise an eligible transmitter read wins. The host ports are served only when neither network port is eligible.
- R5: When both host ports are eligible and no network port is, the host port that was not served most recently wins. Host read wins the first such contest after reset.
- R6: A write port is eligible only when its FIFO holds at least one word.
- R7: A read port is eligible only when its FIFO level plus any read already in flight is less than DEPTH, so a returning word is never lost.
- R8: Read data is written into the granted read FIFO at the clock edge that ends the `mem_ce` cycle.
- R9: Host mode encoding: 0 is programmed I/O, where both DMA requests stay low. 1 is single DMA: `dreq_rd` is high while the host read FIFO is non-empty, and `dreq_wr` is high while the host write FIFO is not full. 2 is burst DMA: `dreq_rd` is high while the read FIFO holds at least `burst_lvl` words, with 0 treated as 1, and `dreq_wr` behaves as in mode 1. 3 behaves as 0.
- R10: While reset is asserted, `mem_ce` is low, both read ports show no valid data, and both write ports are ready.
- R11: `mem_addr` in an access cycle equals the granted port's pointer input in the grant cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxw_valid | input | 1 | Receiver write word valid |
| rxw_ready | output | 1 | Receiver write FIFO has room |
| rxw_data | input | DW | Receiver write word |
| hwr_valid | input | 1 | Host transmit-data word valid |
| hwr_ready | output | 1 | Host write FIFO has room |
| hwr_data | input | DW | Host transmit-data word |
| hrd_valid | output | 1 | Host receive-data word available |
| hrd_ready | input | 1 | Host takes the word |
| hrd_data | output | DW | Host receive-data word |
| txr_valid | output | 1 | Transmit word available |
| txr_ready | input | 1 | Transmitter takes the word |
| txr_data | output | DW | Transmit word |
| host_mode | input | 2 | Host transfer style (R9) |
| burst_lvl | input | CW | Burst DMA read threshold in words |
| dreq_rd | output | 1 | DMA request, host read direction |
| dreq_wr | output | 1 | DMA request, host write direction |
| rxw_ptr | input | AW | Receiver write address |
| hrd_ptr | input | AW | Host read address |
| hwr_ptr | input | AW | Host write address |
| txr_ptr | input | AW | Transmitter read address |
| slot_grant | output | 4 | One-hot grant in this cycle; advance that pointer |
| mem_ce | output | 1 | SRAM chip enable |
| mem_we | output | 1 | SRAM write enable |
| mem_addr | output | AW | SRAM address |
| mem_wdata | output | DW | SRAM write data |
| mem_rdata | input | DW | SRAM read data |

## Verification
The block is driven in several phases, and each phase targets a different part of the arbitration:

- **Producers and consumers idle.** This shows that prefetch stops when the reservation limit is reached.
- **All four streams at full rate.** This shows that the receiver wins every slot it wants and that the transmitter comes before the host.
- **Saturating receiver with a stalled transmitter.** This shows the host ports are pushed aside and then recover.
- **Host-only traffic.** This shows strict alternation between host read and host write.
- **Random rates under each host mode and several burst thresholds.** These separate the single and burst DMA request rules.

Throughout all phases, every word that leaves a read port is compared against a shadow of memory. This catches any write or read that was misaddressed, dropped or reordered.

// File: rtl/pba_pkg.sv
package pba_pkg;
  localparam int NPORT = 4;
  localparam int P_RXW = 0;
  localparam int P_HRD = 1;
  localparam int P_HWR = 2;
  localparam int P_TXR = 3;

  typedef enum logic [1:0] {
    HM_PIO    = 2'd0,
    HM_SINGLE = 2'd1,
    HM_BURST  = 2'd2,
    HM_RSVD   = 2'd3
  } host_mode_e;
endpackage

// File: rtl/pba_fifo.sv
module pba_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [DW-1:0]                push_data,
  input  logic                         pop,
  output logic [DW-1:0]                head,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic                         full,
  output logic                         empty
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

  logic [DW-1:0] slots [DEPTH];
  logic [IW-1:0] wr_ix, rd_ix;
  logic          do_push, do_pop;

  assign full    = (level == CW'(DEPTH));
  assign empty   = (level == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = slots[rd_ix];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ix <= '0;
      rd_ix <= '0;
      level <= '0;
    end else begin
      if (do_push) wr_ix <= (wr_ix == LAST) ? '0 : wr_ix + 1'b1;
      if (do_pop)  rd_ix <= (rd_ix == LAST) ? '0 : rd_ix + 1'b1;
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) slots[wr_ix] <= push_data;
  end
endmodule

// File: rtl/pba_slot_sel.sv
module pba_slot_sel
  import pba_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPORT-1:0] elig,
  output logic [NPORT-1:0] grant
);
  logic last_rd;

  always_comb begin
    grant = '0;
    if (elig[P_RXW])                                 grant[P_RXW] = 1'b1;
    else if (elig[P_TXR])                            grant[P_TXR] = 1'b1;
    else if (elig[P_HRD] && (!elig[P_HWR] || !last_rd)) grant[P_HRD] = 1'b1;
    else if (elig[P_HWR])                            grant[P_HWR] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            last_rd <= 1'b0;
    else if (grant[P_HRD]) last_rd <= 1'b1;
    else if (grant[P_HWR]) last_rd <= 1'b0;
  end
endmodule

// File: rtl/pba_dma_req.sv
module pba_dma_req
  import pba_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input  logic [1:0]    mode,
  input  logic [CW-1:0] burst_lvl,
  input  logic [CW-1:0] rd_level,
  input  logic [CW-1:0] wr_level,
  output logic          dreq_rd,
  output logic          dreq_wr
);
  logic [CW-1:0] thr;
  logic          wr_room;

  assign thr     = (burst_lvl == '0) ? CW'(1) : burst_lvl;
  assign wr_room = (wr_level < CW'(DEPTH));

  always_comb begin
    dreq_rd = 1'b0;
    dreq_wr = 1'b0;
    case (host_mode_e'(mode))
      HM_SINGLE: begin
        dreq_rd = (rd_level != '0);
        dreq_wr = wr_room;
      end
      HM_BURST: begin
        dreq_rd = (rd_level >= thr);
        dreq_wr = wr_room;
      end
      default: begin
        dreq_rd = 1'b0;
        dreq_wr = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/pkt_buf_arbiter.sv
module pkt_buf_arbiter
  import pba_pkg::*;
#(
  parameter int DW    = 16,
  parameter int AW    = 12,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rxw_valid,
  output logic             rxw_ready,
  input  logic [DW-1:0]    rxw_data,
  input  logic             hwr_valid,
  output logic             hwr_ready,
  input  logic [DW-1:0]    hwr_data,
  output logic             hrd_valid,
  input  logic             hrd_ready,
  output logic [DW-1:0]    hrd_data,
  output logic             txr_valid,
  input  logic             txr_ready,
  output logic [DW-1:0]    txr_data,
  input  logic [1:0]       host_mode,
  input  logic [CW-1:0]    burst_lvl,
  output logic             dreq_rd,
  output logic             dreq_wr,
  input  logic [AW-1:0]    rxw_ptr,
  input  logic [AW-1:0]    hrd_ptr,
  input  logic [AW-1:0]    hwr_ptr,
  input  logic [AW-1:0]    txr_ptr,
  output logic [NPORT-1:0] slot_grant,
  output logic             mem_ce,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata
);
  localparam int NW = 2;  // write ports: 0 receiver, 1 host
  localparam int NR = 2;  // read ports:  0 host, 1 transmitter
  localparam logic [CW:0] LIMIT = (CW+1)'(DEPTH);

  // write side
  logic [NW-1:0] w_in_valid, w_full, w_empty, w_pop;
  logic [DW-1:0] w_in_data [NW];
  logic [DW-1:0] w_head    [NW];
  logic [CW-1:0] w_level   [NW];

  // read side
  logic [NR-1:0] r_ready, r_pop, r_full, r_empty, rd_pend;
  logic [DW-1:0] r_head  [NR];
  logic [CW-1:0] r_level [NR];

  logic [NPORT-1:0] elig;
  logic [AW-1:0]    sel_addr;
  logic [DW-1:0]    sel_wdata;
  logic             sel_write;

  assign w_in_valid   = {hwr_valid, rxw_valid};
  assign w_in_data[0] = rxw_data;
  assign w_in_data[1] = hwr_data;
  assign w_pop        = {slot_grant[P_HWR], slot_grant[P_RXW]};
  assign rxw_ready    = !w_full[0];
  assign hwr_ready    = !w_full[1];

  for (genvar w = 0; w < NW; w++) begin : g_wq
    pba_fifo #(.DW(DW), .DEPTH(DEPTH)) u_wq (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (w_in_valid[w]),
      .push_data (w_in_data[w]),
      .pop       (w_pop[w]),
      .head      (w_head[w]),
      .level     (w_level[w]),
      .full      (w_full[w]),
      .empty     (w_empty[w])
    );
  end

  assign r_ready   = {txr_ready, hrd_ready};
  assign r_pop     = r_ready & ~r_empty;
  assign hrd_valid = !r_empty[0];
  assign hrd_data  = r_head[0];
  assign txr_valid = !r_empty[1];
  assign txr_data  = r_head[1];

  for (genvar k = 0; k < NR; k++) begin : g_rq
    pba_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rq (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (rd_pend[k]),
      .push_data (mem_rdata),
      .pop       (r_pop[k]),
      .head      (r_head[k]),
      .level     (r_level[k]),
      .full      (r_full[k]),
      .empty     (r_empty[k])
    );
  end

  // eligibility: writes need data, reads need a reserved free slot
  always_comb begin
    elig        = '0;
    elig[P_RXW] = !w_empty[0];
    elig[P_HWR] = !w_empty[1];
    elig[P_HRD] = !r_full[0] &&
                  (((CW+1)'(r_level[0]) + (CW+1)'(rd_pend[0])) < LIMIT);
    elig[P_TXR] = !r_full[1] &&
                  (((CW+1)'(r_level[1]) + (CW+1)'(rd_pend[1])) < LIMIT);
  end

  pba_slot_sel u_sel (
    .clk   (clk),
    .rst_n (rst_n),
    .elig  (elig),
    .grant (slot_grant)
  );

  always_comb begin
    sel_addr  = rxw_ptr;
    sel_wdata = w_head[0];
    sel_write = 1'b0;
    unique case (1'b1)
      slot_grant[P_RXW]: begin sel_addr = rxw_ptr; sel_wdata = w_head[0]; sel_write = 1'b1; end
      slot_grant[P_HWR]: begin sel_addr = hwr_ptr; sel_wdata = w_head[1]; sel_write = 1'b1; end
      slot_grant[P_HRD]: sel_addr = hrd_ptr;
      slot_grant[P_TXR]: sel_addr = txr_ptr;
      default:           sel_addr = rxw_ptr;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ce    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      rd_pend   <= '0;
    end else begin
      mem_ce  <= |slot_grant;
      mem_we  <= sel_write;
      rd_pend <= {slot_grant[P_TXR], slot_grant[P_HRD]};
      if (|slot_grant) mem_addr <= sel_addr;
      if (sel_write)   mem_wdata <= sel_wdata;
    end
  end

  pba_dma_req #(.DEPTH(DEPTH), .CW(CW)) u_dma (
    .mode      (host_mode),
    .burst_lvl (burst_lvl),
    .rd_level  (r_level[0]),
    .wr_level  (w_level[1]),
    .dreq_rd   (dreq_rd),
    .dreq_wr   (dreq_wr)
  );
endmodule

// File: rtl/pba_checker.sv
module pba_checker
  import pba_pkg::*;
#(
  parameter int AW    = 12,
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPORT-1:0] slot_grant,
  input logic             mem_ce,
  input logic             mem_we,
  input logic [AW-1:0]    mem_addr,
  input logic [AW-1:0]    txr_ptr,
  input logic [1:0]       host_mode,
  input logic             dreq_rd,
  input logic             dreq_wr,
  input logic [CW-1:0]    rx_level,
  input logic [CW-1:0]    hw_level,
  input logic [CW-1:0]    hr_level,
  input logic             hr_pend
);
  assert_single_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_grant));

  assert_strobe_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|slot_grant) |=> mem_ce);

  assert_idle_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(|slot_grant) |=> !mem_ce);

  assert_write_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_grant[P_RXW] || slot_grant[P_HWR]) |=> mem_we);

  assert_read_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_grant[P_HRD] || slot_grant[P_TXR]) |=> !mem_we);

  assert_rx_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level != '0) |-> slot_grant[P_RXW]);

  assert_write_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
    slot_grant[P_HWR] |-> (hw_level != '0));

  assert_no_overfill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(hr_level) + int'(hr_pend)) <= DEPTH);

  assert_pio_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_mode == HM_PIO || host_mode == HM_RSVD) |-> (!dreq_rd && !dreq_wr));

  assert_ptr_latched_R11: assert property (@(posedge clk) disable iff (!rst_n)
    slot_grant[P_TXR] |=> (mem_addr == $past(txr_ptr)));
endmodule

bind pkt_buf_arbiter pba_checker #(.AW(AW), .DEPTH(DEPTH), .CW(CW)) u_pba_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .slot_grant (slot_grant),
  .mem_ce     (mem_ce),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .txr_ptr    (txr_ptr),
  .host_mode  (host_mode),
  .dreq_rd    (dreq_rd),
  .dreq_wr    (dreq_wr),
  .rx_level   (w_level[0]),
  .hw_level   (w_level[1]),
  .hr_level   (r_level[0]),
  .hr_pend    (rd_pend[0])
);

// File: tb/pkt_buf_arbiter_bench.sv
module pkt_buf_arbiter_bench;
  localparam int DW    = 16;
  localparam int AW    = 12;
  localparam int DEPTH = 4;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int MSZ   = 1 << AW;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic          rst_n;
  logic          rxw_valid, rxw_ready, hwr_valid, hwr_ready;
  logic [DW-1:0] rxw_data, hwr_data, hrd_data, txr_data;
  logic          hrd_valid, hrd_ready, txr_valid, txr_ready;
  logic [1:0]    host_mode;
  logic [CW-1:0] burst_lvl;
  logic          dreq_rd, dreq_wr;
  logic [AW-1:0] rxw_ptr, hrd_ptr, hwr_ptr, txr_ptr;
  logic [3:0]    slot_grant;
  logic          mem_ce, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  pkt_buf_arbiter #(.DW(DW), .AW(AW), .DEPTH(DEPTH)) u_pkt_buf_arbiter (
    .clk(clk), .rst_n(rst_n),
    .rxw_valid(rxw_valid), .rxw_ready(rxw_ready), .rxw_data(rxw_data),
    .hwr_valid(hwr_valid), .hwr_ready(hwr_ready), .hwr_data(hwr_data),
    .hrd_valid(hrd_valid), .hrd_ready(hrd_ready), .hrd_data(hrd_data),
    .txr_valid(txr_valid), .txr_ready(txr_ready), .txr_data(txr_data),
    .host_mode(host_mode), .burst_lvl(burst_lvl),
    .dreq_rd(dreq_rd), .dreq_wr(dreq_wr),
    .rxw_ptr(rxw_ptr), .hrd_ptr(hrd_ptr), .hwr_ptr(hwr_ptr), .txr_ptr(txr_ptr),
    .slot_grant(slot_grant),
    .mem_ce(mem_ce), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // external SRAM
  logic [DW-1:0] sram [MSZ];
  assign mem_rdata = sram[mem_addr];
  always @(posedge clk) if (mem_ce && mem_we) sram[mem_addr] <= mem_wdata;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [DW-1:0] m_mem [MSZ];
  logic [DW-1:0] q_rx[$], q_hw[$], q_hr[$], q_tx[$];
  bit            pend_hr, pend_tx, m_last_rd;
  logic [DW-1:0] pdat_hr, pdat_tx;
  logic [3:0]    prev_g, cur_g;
  logic [AW-1:0] prev_addr;
  logic [DW-1:0] prev_wd;
  bit            rx_acc, hw_acc;
  int p_rx, p_hw, p_hr, p_tx;

  task automatic predict();
    bit e_rx, e_hw, e_hr, e_tx, e_drd, e_dwr;
    int thr;
    logic [3:0] g;
    chk(rxw_ready == (q_rx.size() < DEPTH), "R1 rxw_ready", rxw_ready, q_rx.size() < DEPTH);
    chk(hwr_ready == (q_hw.size() < DEPTH), "R1 hwr_ready", hwr_ready, q_hw.size() < DEPTH);
    chk(hrd_valid == (q_hr.size() > 0), "R2 hrd_valid", hrd_valid, q_hr.size() > 0);
    if (q_hr.size() > 0) chk(hrd_data == q_hr[0], "R2 R8 hrd_data", hrd_data, q_hr[0]);
    chk(txr_valid == (q_tx.size() > 0), "R2 txr_valid", txr_valid, q_tx.size() > 0);
    if (q_tx.size() > 0) chk(txr_data == q_tx[0], "R2 R8 txr_data", txr_data, q_tx[0]);

    e_rx = q_rx.size() > 0;
    e_hw = q_hw.size() > 0;
    e_hr = (q_hr.size() + int'(pend_hr)) < DEPTH;
    e_tx = (q_tx.size() + int'(pend_tx)) < DEPTH;
    g = 4'b0000;
    if (e_rx)                            g[0] = 1'b1;
    else if (e_tx)                       g[3] = 1'b1;
    else if (e_hr && (!e_hw || !m_last_rd)) g[1] = 1'b1;
    else if (e_hw)                       g[2] = 1'b1;
    chk(slot_grant == g, "R4 R5 R6 R7 slot_grant", slot_grant, g);
    cur_g = g;

    chk(mem_ce == (prev_g != 0), "R3 mem_ce", mem_ce, prev_g != 0);
    if (prev_g != 0) begin
      chk(mem_we == (prev_g[0] | prev_g[2]), "R3 mem_we", mem_we, prev_g[0] | prev_g[2]);
      chk(mem_addr == prev_addr, "R11 mem_addr", mem_addr, prev_addr);
      if (prev_g[0] | prev_g[2]) chk(mem_wdata == prev_wd, "R3 mem_wdata", mem_wdata, prev_wd);
    end

    thr   = (burst_lvl == 0) ? 1 : int'(burst_lvl);
    e_drd = (host_mode == 2'd1) ? (q_hr.size() > 0) :
            (host_mode == 2'd2) ? (q_hr.size() >= thr) : 1'b0;
    e_dwr = (host_mode == 2'd1 || host_mode == 2'd2) && (q_hw.size() < DEPTH);
    chk(dreq_rd == e_drd, "R9 dreq_rd", dreq_rd, e_drd);
    chk(dreq_wr == e_dwr, "R9 dreq_wr", dreq_wr, e_dwr);
  endtask

  task automatic update();
    bit hr_pop, tx_pop, np_hr, np_tx;
    logic [DW-1:0] nd_hr, nd_tx;
    rx_acc = rxw_valid && (q_rx.size() < DEPTH);
    hw_acc = hwr_valid && (q_hw.size() < DEPTH);
    hr_pop = hrd_ready && (q_hr.size() > 0);
    tx_pop = txr_ready && (q_tx.size() > 0);
    np_hr = 1'b0; np_tx = 1'b0; nd_hr = '0; nd_tx = '0;
    prev_g = cur_g;
    if (cur_g[0]) begin
      prev_addr = rxw_ptr; prev_wd = q_rx[0];
      m_mem[rxw_ptr] = q_rx.pop_front();
      rxw_ptr <= rxw_ptr + 1'b1;
    end
    if (cur_g[2]) begin
      prev_addr = hwr_ptr; prev_wd = q_hw[0];
      m_mem[hwr_ptr] = q_hw.pop_front();
      hwr_ptr <= hwr_ptr + 1'b1;
    end
    if (cur_g[1]) begin
      prev_addr = hrd_ptr; np_hr = 1'b1; nd_hr = m_mem[hrd_ptr];
      hrd_ptr <= hrd_ptr + 1'b1; m_last_rd = 1'b1;
    end
    if (cur_g[2]) m_last_rd = 1'b0;
    if (cur_g[3]) begin
      prev_addr = txr_ptr; np_tx = 1'b1; nd_tx = m_mem[txr_ptr];
      txr_ptr <= txr_ptr + 1'b1;
    end
    if (hr_pop) void'(q_hr.pop_front());
    if (tx_pop) void'(q_tx.pop_front());
    if (pend_hr) q_hr.push_back(pdat_hr);
    if (pend_tx) q_tx.push_back(pdat_tx);
    if (rx_acc) q_rx.push_back(rxw_data);
    if (hw_acc) q_hw.push_back(hwr_data);
    pend_hr = np_hr; pdat_hr = nd_hr;
    pend_tx = np_tx; pdat_tx = nd_tx;
  endtask

  // one cycle: called just after a falling edge
  task automatic run(input int n);
    for (int c = 0; c < n; c++) begin
      if (rx_acc) rxw_valid = 1'b0;
      if (hw_acc) hwr_valid = 1'b0;
      rx_acc = 1'b0; hw_acc = 1'b0;
      if (!rxw_valid && $urandom_range(99) < p_rx) begin rxw_valid = 1'b1; rxw_data = DW'($urandom); end
      if (!hwr_valid && $urandom_range(99) < p_hw) begin hwr_valid = 1'b1; hwr_data = DW'($urandom); end
      hrd_ready = $urandom_range(99) < p_hr;
      txr_ready = $urandom_range(99) < p_tx;
      #1;
      predict();
      @(posedge clk);
      update();
      @(negedge clk);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < MSZ; i++) begin
      sram[i]  = DW'(i) ^ 16'h5a5a;
      m_mem[i] = DW'(i) ^ 16'h5a5a;
    end
    rst_n = 1'b0;
    rxw_valid = 1'b0; hwr_valid = 1'b0; rxw_data = '0; hwr_data = '0;
    hrd_ready = 1'b0; txr_ready = 1'b0;
    host_mode = 2'd0; burst_lvl = '0;
    rxw_ptr = 12'h100; hrd_ptr = 12'h100; hwr_ptr = 12'h800; txr_ptr = 12'h800;
    pend_hr = 1'b0; pend_tx = 1'b0; m_last_rd = 1'b0;
    prev_g = '0; cur_g = '0; prev_addr = '0; prev_wd = '0;
    rx_acc = 1'b0; hw_acc = 1'b0;
    repeat (3) @(negedge clk);
    // R10: state while reset is held
    chk(mem_ce == 1'b0, "R10 mem_ce in reset", mem_ce, 0);
    chk(hrd_valid == 1'b0, "R10 hrd_valid in reset", hrd_valid, 0);
    chk(txr_valid == 1'b0, "R10 txr_valid in reset", txr_valid, 0);
    chk(rxw_ready && hwr_ready, "R10 write ready in reset", rxw_ready && hwr_ready, 1);
    rst_n = 1'b1;

    // idle producers and consumers: prefetch fills then stops (R7)
    p_rx = 0;   p_hw = 0;   p_hr = 0;   p_tx = 0;   run(20);
    // all four streaming (R4)
    p_rx = 100; p_hw = 100; p_hr = 100; p_tx = 100; run(300);
    // random mix, programmed I/O
    p_rx = 50;  p_hw = 50;  p_hr = 50;  p_tx = 50;  run(500);
    // saturating receiver, stalled transmitter (R4 R6)
    p_rx = 100; p_hw = 40;  p_hr = 30;  p_tx = 0;   run(300);
    // host only: alternation (R5)
    p_rx = 0;   p_hw = 100; p_hr = 100; p_tx = 0;   run(300);
    // DMA modes (R9)
    host_mode = 2'd1; p_rx = 30; p_hw = 60; p_hr = 40; p_tx = 60; run(400);
    host_mode = 2'd2; burst_lvl = CW'(3); p_hr = 20; run(400);
    burst_lvl = CW'(0); run(200);
    burst_lvl = CW'(DEPTH); p_hr = 10; run(200);
    host_mode = 2'd3; p_hr = 50; run(200);
    // drain: everything consumed
    p_rx = 0; p_hw = 0; p_hr = 100; p_tx = 100; host_mode = 2'd0; run(100);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule